// File: doc/BRIEF.md
# I2C Bus Interval and Hang Timer

This block is one shared 10-bit counter that advances on the processor's machine-cycle enable and does two jobs for a bit-level I2C interface. Its low three bits time the short minimum intervals a master has to respect on the bus: SCL high, SCL low, stop setup, bus free time and start hold. Each time those three bits roll over, the block raises a one-cycle strobe. The interface releases its next bus action only after that strobe. So the SCL low time it produces is the longer of this minimum and the host's own response time.

While a frame is open, the counter's full width measures how long SCL has stayed still. Every SCL transition reloads the counter. If SCL stays unchanged for roughly a thousand machine cycles, the carry out of bit 9 sends a one-cycle reset pulse to the interface, which then lets go of SCL. The same carry also sets a sticky interrupt request, but only if the timer interrupt is enabled. A 2-bit prescale field picks the preload value, which trades minimum-interval length against clock frequency. The counter only runs while a run-enable bit is set.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, min_done, if_reset and tmo_irq are all 0.
- R2: Prescale code s in presc_sel selects preload 4 - s. After an SCL edge, the first min_done appears after 8 - preload machine-cycle ticks (4 + s ticks).
- R3: min_done lasts exactly one cycle. Without further SCL edges it repeats every 8 ticks, whether or not a frame is open.
- R4: A cycle with scl_edge high reloads the counter with the preload and gives no tick. In the following cycle, min_done and if_reset are 0.
- R5: The counter advances only in cycles where mc_en is 1. With mc_en held at 0, no strobe and no reset appear.
- R6: While frame_active is 0, the upper seven counter bits are held at zero. No reset pulse is issued, however long SCL stays still.
- R7: While frame_active is 1 with no SCL edge, if_reset pulses for exactly one cycle after 1024 - preload ticks (1020 + s). The minimum-interval strobe falls on the same tick.
- R8: A carry with tmr_irq_en at 1 sets tmo_irq. tmo_irq stays at 1 until a cycle with irq_clr at 1, and it is 0 in the cycle after that.
- R9: A carry with tmr_irq_en at 0 still pulses if_reset but leaves tmo_irq at 0.
- R10: While run_en is 0, the counter is held at the preload and neither min_done nor if_reset is raised. Once run_en returns to 1, the first strobe comes 8 - preload ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable; one tick per high cycle |
| run_en | input | 1 | Counter run enable |
| presc_sel | input | 2 | Prescale code selecting the preload |
| scl_edge | input | 1 | One-cycle pulse on any SCL transition |
| frame_active | input | 1 | High between a start and the next stop or reset |
| tmr_irq_en | input | 1 | Timeout interrupt enable |
| irq_clr | input | 1 | Clears the sticky timeout request |
| min_done | output | 1 | One-cycle minimum-interval strobe |
| if_reset | output | 1 | One-cycle reset pulse to the I2C interface |
| tmo_irq | output | 1 | Sticky timeout interrupt request |

## Verification
The minimum-interval strobe and the hang reset come from the same counter. Bit 9's carry can only happen when the low three bits are all ones, so min_done and if_reset must rise together on the timeout tick. The bench leaves SCL still for a whole frame under a random machine-cycle duty. It records the tick number of every strobe and of the reset, and it requires the last strobe and the reset on tick 1024 - preload, with 128 strobes counted up to that point. A late edge that reloads the counter just before that tick is also applied, and the bench expects both outputs to stay low.

// File: rtl/i2c_bus_timer_pkg.sv
// Shared sizes and preload mapping for the I2C bus interval and hang timer.
// Assumes the prescale code is small enough that the preload fits the low field.
package i2c_bus_timer_pkg;
    localparam int CNT_W   = 10;
    localparam int LO_W    = 3;
    localparam int PRESC_W = 2;
    localparam int HI_W    = CNT_W - LO_W;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LO_W-1:0]  lo_t;

    // Preload is the prescale range minus the code: larger code, longer interval.
    function automatic lo_t preload_of(input logic [PRESC_W-1:0] sel);
        return lo_t'((1 << PRESC_W) - int'(sel));
    endfunction
endpackage

// File: rtl/ibt_preload.sv
// Converts the prescale code into the counter preload value.
// Purely combinational; assumes presc_sel is static or changes between intervals.
module ibt_preload
    import i2c_bus_timer_pkg::*;
(
    input  logic [PRESC_W-1:0] presc_sel,
    output lo_t                preload
);
    // Map code to preload.
    always_comb preload = preload_of(presc_sel);
endmodule

// File: rtl/ibt_counter.sv
// Shared 10-bit interval/hang counter. The low field free-runs on machine
// ticks; the upper field advances only while a frame is open. SCL edges and
// a stopped run enable reload the preload. Exposes the low-field rollover
// and the full-width carry as single-cycle combinational events.
module ibt_counter
    import i2c_bus_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mc_en,
    input  logic run_en,
    input  logic scl_edge,
    input  logic frame_active,
    input  lo_t  preload,
    output logic lo_carry,
    output logic full_carry
);
    cnt_t cnt;
    logic tick;
    cnt_t reload_val;

    // A tick is a running machine cycle not overridden by an SCL edge.
    always_comb begin
        tick       = run_en && mc_en && !scl_edge;
        reload_val = {{HI_W{1'b0}}, preload};
        lo_carry   = tick && (cnt[LO_W-1:0] == {LO_W{1'b1}});
        full_carry = tick && frame_active && (cnt == {CNT_W{1'b1}});
    end

    // Counter update: reload, free-run low field, or full count in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_en || scl_edge) begin
            cnt <= reload_val;
        end else if (mc_en) begin
            if (full_carry)
                cnt <= reload_val;
            else if (!frame_active)
                cnt <= {{HI_W{1'b0}}, cnt[LO_W-1:0] + lo_t'(1)};
            else
                cnt <= cnt + cnt_t'(1);
        end
    end
endmodule

// File: rtl/ibt_events.sv
// Registers the counter events into the block outputs: a minimum-interval
// strobe, a one-cycle interface reset and a sticky timeout request. Assumes
// the input events are single-cycle.
module ibt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_carry,
    input  logic full_carry,
    input  logic tmr_irq_en,
    input  logic irq_clr,
    output logic min_done,
    output logic if_reset,
    output logic tmo_irq
);
    // Pulse outputs follow their events by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_done <= 1'b0;
            if_reset <= 1'b0;
        end else begin
            min_done <= lo_carry;
            if_reset <= full_carry;
        end
    end

    // Sticky request: a new carry wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_irq <= 1'b0;
        else if (full_carry && tmr_irq_en)
            tmo_irq <= 1'b1;
        else if (irq_clr)
            tmo_irq <= 1'b0;
    end
endmodule

// File: rtl/i2c_bus_timer.sv
// Top of the I2C bus interval and hang timer. One shared counter times the
// master's minimum bus intervals and detects SCL inactivity during a frame.
// Assumes scl_edge is a one-cycle pulse synchronous to clk.
module i2c_bus_timer
    import i2c_bus_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_en,
    input  logic               run_en,
    input  logic [PRESC_W-1:0] presc_sel,
    input  logic               scl_edge,
    input  logic               frame_active,
    input  logic               tmr_irq_en,
    input  logic               irq_clr,
    output logic               min_done,
    output logic               if_reset,
    output logic               tmo_irq
);
    lo_t  preload;
    logic lo_carry;
    logic full_carry;

    ibt_preload u_pre (
        .presc_sel (presc_sel),
        .preload   (preload)
    );

    ibt_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .mc_en        (mc_en),
        .run_en       (run_en),
        .scl_edge     (scl_edge),
        .frame_active (frame_active),
        .preload      (preload),
        .lo_carry     (lo_carry),
        .full_carry   (full_carry)
    );

    ibt_events u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_carry   (lo_carry),
        .full_carry (full_carry),
        .tmr_irq_en (tmr_irq_en),
        .irq_clr    (irq_clr),
        .min_done   (min_done),
        .if_reset   (if_reset),
        .tmo_irq    (tmo_irq)
    );
endmodule

// File: rtl/i2c_bus_timer_chk.sv
// Property checker for the I2C bus interval and hang timer, bound to the top.
module i2c_bus_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic scl_edge,
    input logic frame_active,
    input logic tmr_irq_en,
    input logic irq_clr,
    input logic min_done,
    input logic if_reset,
    input logic tmo_irq
);
    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_done |=> !min_done);
    // R7
    reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |=> !if_reset);
    // R4
    edge_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_edge |=> (!min_done && !if_reset));
    // R6
    idle_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !if_reset);
    // R10
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!min_done && !if_reset));
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_irq && !irq_clr) |=> tmo_irq);
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> (if_reset && $past(tmr_irq_en)));
    // R7
    reset_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |-> min_done);
endmodule

bind i2c_bus_timer i2c_bus_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .scl_edge     (scl_edge),
    .frame_active (frame_active),
    .tmr_irq_en   (tmr_irq_en),
    .irq_clr      (irq_clr),
    .min_done     (min_done),
    .if_reset     (if_reset),
    .tmo_irq      (tmo_irq)
);

// File: tb/tb_i2c_bus_timer.sv
module tb_i2c_bus_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] presc_sel = 2'd0;
    logic       scl_edge = 1'b0;
    logic       frame_active = 1'b0;
    logic       tmr_irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       min_done;
    logic       if_reset;
    logic       tmo_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int t_first, t_last_min, t_rst, n_min, n_rst;

    i2c_bus_timer dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .run_en(run_en),
        .presc_sel(presc_sel), .scl_edge(scl_edge), .frame_active(frame_active),
        .tmr_irq_en(tmr_irq_en), .irq_clr(irq_clr),
        .min_done(min_done), .if_reset(if_reset), .tmo_irq(tmo_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_pre(input int s);   return 4 - s;            endfunction
    function automatic int exp_first(input int s); return 8 - exp_pre(s);   endfunction
    function automatic int exp_tmo(input int s);   return 1024 - exp_pre(s); endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one SCL edge cycle; sample the cycle after it.
    task automatic apply_edge();
        scl_edge = 1'b1;
        mc_en = ($urandom % 2) != 0;
        @(posedge clk); @(negedge clk);
        scl_edge = 1'b0;
    endtask

    // Run until `limit` ticks (duty>0) or `limit` cycles (duty==0), logging events.
    task automatic run_ticks(input int limit, input int duty);
        int t = 0;
        int cyc = 0;
        t_first = -1; t_last_min = -1; t_rst = -1; n_min = 0; n_rst = 0;
        while ((duty > 0) ? (t < limit) : (cyc < limit)) begin
            mc_en = (duty > 0) ? (($urandom % 4) < duty) : 1'b0;
            @(posedge clk); @(negedge clk);
            cyc++;
            if (mc_en) t++;
            if (min_done) begin
                n_min++; t_last_min = t;
                if (t_first < 0) t_first = t;
            end
            if (if_reset) begin
                n_rst++;
                if (t_rst < 0) t_rst = t;
            end
        end
        mc_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!min_done && !if_reset && !tmo_irq, "R1", {min_done, if_reset, tmo_irq}, 0);
        rst_n = 1'b1;
        run_en = 1'b1;

        // R2, R3: each prescale code, no frame
        for (int s = 0; s < 4; s++) begin
            presc_sel = 2'(s);
            apply_edge();
            check(!min_done && !if_reset, "R4", min_done, 0);
            run_ticks(40, 3);
            check(t_first == exp_first(s), "R2", t_first, exp_first(s));
            check(n_min == (40 - exp_first(s)) / 8 + 1, "R3", n_min, (40 - exp_first(s)) / 8 + 1);
        end

        // R4: edge in the middle of an interval restarts it
        presc_sel = 2'($urandom % 4);
        apply_edge();
        run_ticks(2, 2);
        apply_edge();
        run_ticks(12, 2);
        check(t_first == exp_first(int'(presc_sel)), "R4", t_first, exp_first(int'(presc_sel)));

        // R5: no machine ticks, no strobes
        apply_edge();
        run_ticks(60, 0);
        check(n_min == 0 && n_rst == 0, "R5", n_min + n_rst, 0);
        run_ticks(12, 4);
        check(t_first == exp_first(int'(presc_sel)), "R5", t_first, exp_first(int'(presc_sel)));

        // R6: long silence outside a frame never resets
        frame_active = 1'b0;
        apply_edge();
        run_ticks(1500, 3);
        check(n_rst == 0 && !tmo_irq, "R6", n_rst, 0);

        // R7, R8: timeout in a frame with interrupt enabled
        presc_sel = 2'($urandom % 4);
        tmr_irq_en = 1'b1;
        frame_active = 1'b1;
        apply_edge();
        run_ticks(exp_tmo(int'(presc_sel)), 3);
        check(t_rst == exp_tmo(int'(presc_sel)), "R7", t_rst, exp_tmo(int'(presc_sel)));
        check(n_rst == 1, "R7", n_rst, 1);
        check(t_last_min == t_rst && n_min == 128, "R7", n_min, 128);
        check(tmo_irq, "R8", tmo_irq, 1);
        run_ticks(20, 0);
        check(tmo_irq && !if_reset, "R8", tmo_irq, 1);
        irq_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_clr = 1'b0;
        check(!tmo_irq, "R8", tmo_irq, 0);

        // R4: late edge just before the timeout tick
        apply_edge();
        run_ticks(exp_tmo(int'(presc_sel)) - 1, 4);
        apply_edge();
        check(!if_reset && !min_done, "R4", if_reset, 0);
        run_ticks(5, 4);
        check(n_rst == 0, "R4", n_rst, 0);

        // R9: timeout with interrupt disabled
        tmr_irq_en = 1'b0;
        presc_sel = 2'd3;
        apply_edge();
        run_ticks(exp_tmo(3), 2);
        check(n_rst == 1 && t_rst == exp_tmo(3), "R9", t_rst, exp_tmo(3));
        check(!tmo_irq, "R9", tmo_irq, 0);

        // R10: stopped counter
        run_en = 1'b0;
        presc_sel = 2'd1;
        run_ticks(100, 4);
        check(n_min == 0 && n_rst == 0, "R10", n_min + n_rst, 0);
        run_en = 1'b1;
        run_ticks(12, 3);
        check(t_first == exp_first(1), "R10", t_first, exp_first(1));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule